// File: doc/BRIEF.md
# Adjustable Time-of-Day Clock Counter

This block keeps a free-running time of day: a 48-bit count of seconds, a nanoseconds count below one billion, and a 16-bit fraction of a nanosecond. On every clock cycle it adds a step held in 20-bit fixed point, with 4 whole and 16 fractional nanosecond bits. When the nanoseconds cross one second they wrap and the seconds go up by one.

Software reaches the counter through a small word-wide register port with separate read and write strobes. Reading the nanoseconds word freezes a copy of the seconds, so the following seconds reads belong to the same instant. Seconds writes are held in a staging register and take effect, together with the new nanoseconds, only when the nanoseconds word is written. Two correction mechanisms act on the step. An offset adjustment swaps in an alternate step for a programmed number of cycles and then clears itself. A drift correction adds a small fractional amount once every N cycles.

Top module: `tod_clock_top`

## Requirements
- R1: A read of the nanoseconds word (offset 0x108) returns the live nanoseconds and, at the same clock edge, copies the live seconds into a snapshot. The seconds words return that snapshot, unchanged, until the next nanoseconds read.
- R2: Writes to the seconds words are staged and leave the running time untouched. A write to the nanoseconds word loads the staged seconds and the written nanoseconds (bits 29:0) into the live time in one edge, and clears the fraction.
- R3: Seconds are 48 bits. The word at 0x104 holds seconds bits 31:0. The word at 0x100 holds seconds bits 47:32 in its bits 15:0, and writes to its bits 31:16 are dropped. Seconds wrap from all ones to zero.
- R4: The step word (0x110) is 20 bits, with bits 19:16 in whole nanoseconds and bits 15:0 in fractional nanoseconds. It is added to the time on every cycle in which no load happens, and the fraction carries into the nanoseconds.
- R5: When the nanoseconds would reach or pass 1,000,000,000, including when one step crosses that value, one billion is subtracted and the seconds go up by one.
- R6: Writing N to the adjust-count word (0x118) makes the adjust-step word (0x114) replace the normal step for the next N cycles. The count reads back the remaining cycles, decrements each cycle and reads zero when done. Both words are 20 bits.
- R7: With drift rate R (0x120, 16 bits) and drift amount A (0x11C, 16 bits of fractional nanoseconds), A is added once every R cycles. The first addition comes R cycles after the edge that follows the rate write. R = 0 or A = 0 disables the correction.
- R8: The read-only word at 0x038 returns the parameter CLK_FREQ_HZ, the nominal clock frequency in hertz.
- R9: After a synchronous reset the time, the snapshot, the staged seconds, the adjust count, the adjust step and both drift fields are zero, and the step equals the parameter DEF_STEP (default 0x40000, 4 ns).
- R10: Read data appears on `rd_data` in the cycle after `rd_en` and holds until the next read. Unused upper bits read as zero, and an unmapped offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the register word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |

## Verification
On every cycle, the embedded properties check that the nanoseconds stay below one billion after a normal step and that the seconds move by zero or one when no load happens. They also check that a running adjust count drops by exactly one per cycle, that drift additions never come back to back when the rate exceeds one, that the seconds snapshot changes only after a nanoseconds read, and that unmapped reads return zero. Only the bench scenarios can show the exact arithmetic. These cover fractional carries, a wrap landing exactly on one billion, the 32-bit and 48-bit seconds roll-overs, the cycle in which an adjustment starts and stops, and the phase of the first drift addition. They also show that staged seconds stay invisible until the commit.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int SEC_W   = 48;
    localparam int NS_W    = 30;
    localparam int FRAC_W  = 16;
    localparam int STEP_W  = 20;
    localparam int DRIFT_W = 16;
    localparam int CNT_W   = 20;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int SEC_LO_W = 32;
    localparam int SEC_HI_W = SEC_W - SEC_LO_W;

    localparam logic [NS_W-1:0] NS_PER_SEC = NS_W'(1_000_000_000);

    localparam logic [ADDR_W-1:0] OFS_FREQ    = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_SEC_HI  = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_SEC_LO  = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_NSEC    = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_STEP    = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_ADJ_STP = 12'h114;
    localparam logic [ADDR_W-1:0] OFS_ADJ_CNT = 12'h118;
    localparam logic [ADDR_W-1:0] OFS_DR_AMT  = 12'h11C;
    localparam logic [ADDR_W-1:0] OFS_DR_RATE = 12'h120;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } tod_val_t;

    function automatic logic ofs_mapped(input logic [ADDR_W-1:0] a);
        return (a == OFS_FREQ)    || (a == OFS_SEC_HI)  || (a == OFS_SEC_LO) ||
               (a == OFS_NSEC)    || (a == OFS_STEP)    || (a == OFS_ADJ_STP) ||
               (a == OFS_ADJ_CNT) || (a == OFS_DR_AMT)  || (a == OFS_DR_RATE);
    endfunction
endpackage

// File: rtl/tod_time.sv
module tod_time
    import tod_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STEP_W-1:0]  step,
    input  logic [DRIFT_W-1:0] drift_add,
    input  logic               load,
    input  logic [SEC_W-1:0]   load_sec,
    input  logic [NS_W-1:0]    load_ns,
    output tod_val_t           now
);
    localparam int ACC_W = NS_W + FRAC_W + 1;

    tod_val_t          t_d, t_q;
    logic [ACC_W-1:0]  acc;
    logic [NS_W:0]     ns_raw;
    logic              wrap;

    always_comb begin
        acc    = {1'b0, t_q.ns, t_q.frac} + ACC_W'(step) + ACC_W'(drift_add);
        ns_raw = acc[ACC_W-1:FRAC_W];
        wrap   = ns_raw >= {1'b0, NS_PER_SEC};
        t_d.frac = acc[FRAC_W-1:0];
        if (wrap) begin
            t_d.ns  = NS_W'(ns_raw - {1'b0, NS_PER_SEC});
            t_d.sec = t_q.sec + SEC_W'(1);
        end else begin
            t_d.ns  = ns_raw[NS_W-1:0];
            t_d.sec = t_q.sec;
        end
        if (load) begin
            t_d.sec  = load_sec;
            t_d.ns   = load_ns;
            t_d.frac = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign now = t_q;

    // R5: a normal step never leaves nanoseconds at or above one second
    p_ns_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && ($past(t_q.ns) < NS_PER_SEC))
        |-> (t_q.ns < NS_PER_SEC));

    // R5: without a load the seconds hold or advance by exactly one
    p_sec_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load))
        |-> ((t_q.sec == $past(t_q.sec)) || (t_q.sec == $past(t_q.sec) + SEC_W'(1))));
endmodule

// File: rtl/tod_rate.sv
module tod_rate
    import tod_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STEP_W-1:0]  base_step,
    input  logic [STEP_W-1:0]  adj_step,
    input  logic               cnt_wr,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic [DRIFT_W-1:0] drift_amt,
    input  logic [DRIFT_W-1:0] drift_rate,
    input  logic               rate_wr,
    output logic [STEP_W-1:0]  step,
    output logic [DRIFT_W-1:0] drift_add,
    output logic [CNT_W-1:0]   adj_left
);
    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [DRIFT_W-1:0] dcnt;
    } rate_st_t;

    rate_st_t s_d, s_q;
    logic     drift_on, fire, adj_busy;

    always_comb begin
        s_d      = s_q;
        adj_busy = s_q.cnt != '0;
        drift_on = (drift_rate != '0) && (drift_amt != '0);
        fire     = drift_on && (s_q.dcnt == DRIFT_W'(drift_rate - DRIFT_W'(1)));

        step      = adj_busy ? adj_step : base_step;
        drift_add = fire ? drift_amt : '0;

        if (cnt_wr)        s_d.cnt = cnt_wdata;
        else if (adj_busy) s_d.cnt = s_q.cnt - CNT_W'(1);

        if (rate_wr || !drift_on || fire) s_d.dcnt = '0;
        else                              s_d.dcnt = s_q.dcnt + DRIFT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign adj_left = s_q.cnt;

    // R6: a running adjustment loses exactly one cycle per clock
    p_adj_countdown_r6: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && (adj_left != '0)) |=> (adj_left == $past(adj_left) - CNT_W'(1)));

    // R7: with a rate above one, two drift additions are never adjacent
    p_drift_gap_r7: assert property (@(posedge clk) disable iff (rst)
        ((drift_add != '0) && (drift_rate > DRIFT_W'(1)) && !rate_wr) |=> (drift_add == '0));
endmodule

// File: rtl/tod_regs.sv
module tod_regs
    import tod_pkg::*;
#(
    parameter logic [DATA_W-1:0] CLK_FREQ_HZ = 32'd250_000_000,
    parameter logic [STEP_W-1:0] DEF_STEP    = 20'h40000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  tod_val_t           now,
    input  logic [CNT_W-1:0]   adj_left,
    output logic [DATA_W-1:0]  rd_data,
    output logic [STEP_W-1:0]  base_step,
    output logic [STEP_W-1:0]  adj_step,
    output logic [DRIFT_W-1:0] drift_amt,
    output logic [DRIFT_W-1:0] drift_rate,
    output logic               cnt_wr,
    output logic               rate_wr,
    output logic               load,
    output logic [SEC_W-1:0]   load_sec,
    output logic [NS_W-1:0]    load_ns
);
    typedef struct packed {
        logic [STEP_W-1:0]  step;
        logic [STEP_W-1:0]  adj_step;
        logic [DRIFT_W-1:0] dr_amt;
        logic [DRIFT_W-1:0] dr_rate;
        logic [SEC_W-1:0]   stage_sec;
        logic [SEC_W-1:0]   snap_sec;
        logic [DATA_W-1:0]  rdata;
    } regs_st_t;

    regs_st_t s_d, s_q;
    logic     ns_rd;

    always_comb begin
        s_d     = s_q;
        cnt_wr  = 1'b0;
        rate_wr = 1'b0;
        load    = 1'b0;
        ns_rd   = rd_en && (addr == OFS_NSEC);

        if (wr_en) begin
            case (addr)
                OFS_SEC_HI:  s_d.stage_sec[SEC_W-1:SEC_LO_W] = wr_data[SEC_HI_W-1:0];
                OFS_SEC_LO:  s_d.stage_sec[SEC_LO_W-1:0]     = wr_data[SEC_LO_W-1:0];
                OFS_NSEC:    load = 1'b1;
                OFS_STEP:    s_d.step     = wr_data[STEP_W-1:0];
                OFS_ADJ_STP: s_d.adj_step = wr_data[STEP_W-1:0];
                OFS_ADJ_CNT: cnt_wr = 1'b1;
                OFS_DR_AMT:  s_d.dr_amt   = wr_data[DRIFT_W-1:0];
                OFS_DR_RATE: begin
                    s_d.dr_rate = wr_data[DRIFT_W-1:0];
                    rate_wr     = 1'b1;
                end
                default: ;
            endcase
        end

        if (rd_en) begin
            case (addr)
                OFS_FREQ:    s_d.rdata = CLK_FREQ_HZ;
                OFS_SEC_HI:  s_d.rdata = DATA_W'(s_q.snap_sec[SEC_W-1:SEC_LO_W]);
                OFS_SEC_LO:  s_d.rdata = DATA_W'(s_q.snap_sec[SEC_LO_W-1:0]);
                OFS_NSEC:    s_d.rdata = DATA_W'(now.ns);
                OFS_STEP:    s_d.rdata = DATA_W'(s_q.step);
                OFS_ADJ_STP: s_d.rdata = DATA_W'(s_q.adj_step);
                OFS_ADJ_CNT: s_d.rdata = DATA_W'(adj_left);
                OFS_DR_AMT:  s_d.rdata = DATA_W'(s_q.dr_amt);
                OFS_DR_RATE: s_d.rdata = DATA_W'(s_q.dr_rate);
                default:     s_d.rdata = '0;
            endcase
        end
        if (ns_rd) s_d.snap_sec = now.sec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            s_q.step <= DEF_STEP;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data    = s_q.rdata;
    assign base_step  = s_q.step;
    assign adj_step   = s_q.adj_step;
    assign drift_amt  = s_q.dr_amt;
    assign drift_rate = s_q.dr_rate;
    assign load_sec   = s_q.stage_sec;
    assign load_ns    = wr_data[NS_W-1:0];

    // R1: the seconds snapshot moves only after a nanoseconds read
    p_snap_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ns_rd)) |-> (s_q.snap_sec == $past(s_q.snap_sec)));

    // R10: an unmapped offset reads back as zero one cycle later
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !ofs_mapped(addr)) |=> (rd_data == '0));

    // R10: read data holds while no read is issued
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data));
endmodule

// File: rtl/tod_clock_top.sv
module tod_clock_top
    import tod_pkg::*;
#(
    parameter logic [DATA_W-1:0] CLK_FREQ_HZ = 32'd250_000_000,
    parameter logic [STEP_W-1:0] DEF_STEP    = 20'h40000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    tod_val_t           now;
    logic [CNT_W-1:0]   adj_left;
    logic [STEP_W-1:0]  base_step, adj_step, step;
    logic [DRIFT_W-1:0] drift_amt, drift_rate, drift_add;
    logic               cnt_wr, rate_wr, load;
    logic [SEC_W-1:0]   load_sec;
    logic [NS_W-1:0]    load_ns;

    tod_regs #(
        .CLK_FREQ_HZ (CLK_FREQ_HZ),
        .DEF_STEP    (DEF_STEP)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .now        (now),
        .adj_left   (adj_left),
        .rd_data    (rd_data),
        .base_step  (base_step),
        .adj_step   (adj_step),
        .drift_amt  (drift_amt),
        .drift_rate (drift_rate),
        .cnt_wr     (cnt_wr),
        .rate_wr    (rate_wr),
        .load       (load),
        .load_sec   (load_sec),
        .load_ns    (load_ns)
    );

    tod_rate u_rate (
        .clk        (clk),
        .rst        (rst),
        .base_step  (base_step),
        .adj_step   (adj_step),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (wr_data[CNT_W-1:0]),
        .drift_amt  (drift_amt),
        .drift_rate (drift_rate),
        .rate_wr    (rate_wr),
        .step       (step),
        .drift_add  (drift_add),
        .adj_left   (adj_left)
    );

    tod_time u_time (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .drift_add (drift_add),
        .load      (load),
        .load_sec  (load_sec),
        .load_ns   (load_ns),
        .now       (now)
    );
endmodule

// File: tb/sim_tod_clock_top.sv
`timescale 1ns/1ps
module sim_tod_clock_top;
    localparam logic [11:0] A_FREQ = 12'h038, A_SH = 12'h100, A_SL = 12'h104,
                            A_NS = 12'h108, A_STEP = 12'h110, A_AST = 12'h114,
                            A_ACN = 12'h118, A_DAM = 12'h11C, A_DRT = 12'h120;
    // {sec 48, ns 32, idle 8, expected sec 48, expected ns 32}
    localparam int NV = 5;
    localparam logic [167:0] VEC [NV] = '{
        {48'h1234_89AB_CDEF, 32'd100,         8'd5, 48'h1234_89AB_CDEF, 32'd120},
        {48'd5,              32'd999_999_990, 8'd2, 48'd5,              32'd999_999_998},
        {48'd5,              32'd999_999_996, 8'd1, 48'd6,              32'd0},
        {48'h0000_FFFF_FFFF, 32'd999_999_999, 8'd1, 48'h0001_0000_0000, 32'd3},
        {48'hFFFF_FFFF_FFFF, 32'd999_999_998, 8'd1, 48'd0,              32'd2}
    };

    logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0, rd_data, r;
    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tod_clock_top u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                      .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        rd(A_NS, r);   chk("R9 ns after reset", r, 32'd0);
        rd(A_SL, r);   chk("R9 sec lo after reset", r, 32'd0);
        rd(A_SH, r);   chk("R9 sec hi after reset", r, 32'd0);
        rd(A_STEP, r); chk("R9 default step", r, 32'h40000);
        rd(A_AST, r);  chk("R9 adjust step", r, 32'd0);
        rd(A_ACN, r);  chk("R9 adjust count", r, 32'd0);
        rd(A_DAM, r);  chk("R9 drift amount", r, 32'd0);
        rd(A_DRT, r);  chk("R9 drift rate", r, 32'd0);
        rd(A_FREQ, r); chk("R8 frequency", r, 32'd250_000_000);
        rd(12'h200, r); chk("R10 unmapped", r, 32'd0);

        // R2 R3 R5 vector walk at 4 ns per cycle
        for (int i = 0; i < NV; i++) begin
            wr(A_SH, {16'h0, VEC[i][167:152]});
            wr(A_SL, VEC[i][151:120]);
            wr(A_NS, VEC[i][119:88]);
            repeat (int'(VEC[i][87:80])) @(negedge clk);
            rd(A_NS, r); chk($sformatf("R5 vec%0d ns", i), r, VEC[i][31:0]);
            rd(A_SL, r); chk($sformatf("R1 R3 vec%0d sec lo", i), r, VEC[i][63:32]);
            rd(A_SH, r); chk($sformatf("R3 vec%0d sec hi", i), r, {16'h0, VEC[i][79:64]});
        end

        // R2 staged seconds have no effect before the nanoseconds write
        wr(A_SH, 32'hABCD_0007);
        wr(A_SL, 32'd8);
        rd(A_NS, r);
        rd(A_SL, r); chk("R2 staged lo invisible", r, 32'd0);
        rd(A_SH, r); chk("R2 staged hi invisible", r, 32'd0);
        wr(A_NS, 32'd500);
        rd(A_NS, r); chk("R2 commit ns", r, 32'd500);
        rd(A_SL, r); chk("R2 commit sec lo", r, 32'd8);
        rd(A_SH, r); chk("R3 commit sec hi upper dropped", r, 32'd7);
        repeat (3) @(negedge clk);
        rd(A_SL, r); chk("R1 snapshot held", r, 32'd8);

        // R4 fractional step
        wr(A_STEP, 32'hFFF1_8000);
        rd(A_STEP, r); chk("R4 step width", r, 32'h18000);
        wr(A_NS, 32'd0);
        repeat (3) @(negedge clk);
        rd(A_NS, r); chk("R4 fractional carry", r, 32'd4);
        wr(A_STEP, 32'h40000);

        // R6 offset adjustment
        wr(A_NS, 32'd0);
        wr(A_AST, 32'h000A_0000);
        wr(A_ACN, 32'd3);
        rd(A_ACN, r); chk("R6 count loaded", r, 32'd3);
        rd(A_NS, r);  chk("R6 first adjusted step", r, 32'd18);
        rd(A_ACN, r); chk("R6 count decrement", r, 32'd1);
        rd(A_ACN, r); chk("R6 count cleared", r, 32'd0);
        rd(A_NS, r);  chk("R6 normal step resumes", r, 32'd42);
        rd(A_AST, r); chk("R6 adjust step readback", r, 32'hA0000);

        // R7 drift correction
        wr(A_DAM, 32'h8000);
        wr(A_DRT, 32'd2);
        wr(A_NS, 32'd0);
        repeat (4) @(negedge clk);
        rd(A_NS, r); chk("R7 drift every 2 cycles", r, 32'd17);
        wr(A_DAM, 32'd0);
        wr(A_NS, 32'd0);
        repeat (4) @(negedge clk);
        rd(A_NS, r); chk("R7 zero amount disables", r, 32'd16);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule